// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block is the send side of an asynchronous serial port. The host writes bytes into a 16-entry queue. A shift engine takes them one at a time and sends each as a frame on a single output line. A frame starts with a low start bit, carries 7 or 8 data bits with the least significant bit first, can add an even or odd parity bit, and ends with one or two high stop bits. All bit timing comes from a one-cycle baud tick that is generated outside the block. Each bit period begins at a tick.

Flow control comes from an active-low clear-to-send input. While the peer holds it high, no new frame begins. A frame that has already started always runs to its end. The host can read the current number of queued bytes at any time. When the queue drains to a programmable low-water mark, two separately enabled outputs tell the system to refill it: an interrupt for the processor and a transfer request for a DMA-style controller. A write to a full queue is discarded and sets a sticky overflow flag.

Top module: `txq_serializer`

## Requirements
- R1: While reset is held, `txd` is 1, `fill_cnt` is 0 and `ovf_flag` is 0.
- R2: A write is accepted at a clock edge only if `fill_cnt` was below 16 before that edge, and it then adds one to `fill_cnt`. The start of a frame removes the oldest entry and subtracts one. `fill_cnt` never exceeds 16 and changes by at most one per clock.
- R3: A write made while `fill_cnt` is 16 is dropped and sets `ovf_flag` from the next cycle onward. `ovf_clr` clears the flag only in a cycle with no dropped write, because setting the flag wins over clearing it.
- R4: A frame is a 0 start bit, then the data bits LSB first (7 bits when `cfg_short_word` is 1, otherwise 8), then the stop bits (two when `cfg_two_stop` is 1, otherwise one) at level 1. `txd` changes only at clock edges where `baud_tick` is 1, so each bit lasts one tick interval.
- R5: When `cfg_parity_en` is 1, a parity bit follows the last data bit. With `cfg_parity_odd` at 0 it is the XOR of the data bits sent (even parity). With `cfg_parity_odd` at 1 it is the inverse of that XOR (odd parity).
- R6: A frame starts only at a tick edge where the engine is idle, the queue is not empty and `cts_n` is 0. Raising `cts_n` during a frame does not cut that frame short.
- R7: When no frame is being sent, `txd` is 1. After the tick that ends the last stop bit, the line stays high for at least one full tick interval before the next start bit.
- R8: `empty_irq` is 1 exactly when `cfg_irq_en` is 1 and `fill_cnt` is at or below the threshold chosen by `cfg_trig`: 0 selects 1 entry, 1 selects 2, 2 selects 4 and 3 selects 8.
- R9: `xfer_req` is 1 exactly when `cfg_dreq_en` is 1 and the same threshold condition holds. It does not depend on `cfg_irq_en`.
- R10: The format inputs (`cfg_short_word`, `cfg_parity_en`, `cfg_parity_odd`, `cfg_two_stop`) are sampled when a frame starts. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe into the queue |
| wr_data | input | DATA_W | Byte to queue |
| cfg_short_word | input | 1 | 1 = send 7 data bits, 0 = send 8 |
| cfg_parity_en | input | 1 | Add a parity bit |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_trig | input | 2 | Low-water threshold select (1, 2, 4, 8) |
| cfg_irq_en | input | 1 | Enables `empty_irq` |
| cfg_dreq_en | input | 1 | Enables `xfer_req` |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| cts_n | input | 1 | Peer ready to receive, active low |
| txd | output | 1 | Serial data line |
| fill_cnt | output | $clog2(DEPTH+1) | Number of bytes in the queue |
| empty_irq | output | 1 | Queue at or below the threshold, interrupt |
| xfer_req | output | 1 | Queue at or below the threshold, transfer request |
| ovf_flag | output | 1 | Sticky flag for a dropped write |

## Verification
The bound checker watches these properties on every clock:
- the fill-count bound and the one-step change rule,
- dropped writes setting the overflow flag and the flag staying set until it is cleared,
- `txd` moving only on tick edges,
- frame starts happening only with clear-to-send low, on a tick, with a non-empty queue,
- the line staying high whenever the engine is idle.

Some behaviour only the bench scenarios can show, through a model that is compared every cycle:
- the exact bit order of each format, including 7-bit data, both parities and two stop bits,
- a frame finishing after clear-to-send is raised partway through,
- format changes made mid-frame being ignored,
- the threshold outputs following the queue as it drains under each trigger setting and each combination of enables.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
package txq_pkg;

   // Low-water threshold selector: level = 1 << code
   typedef enum logic [1:0] {
      TRIG_1 = 2'd0,
      TRIG_2 = 2'd1,
      TRIG_4 = 2'd2,
      TRIG_8 = 2'd3
   } trig_sel_e;

   // Frame format captured at each frame start
   typedef struct packed {
      logic short_word;
      logic par_en;
      logic par_odd;
      logic two_stop;
   } frame_cfg_t;

endpackage

// File: rtl/txq_fifo.sv
`timescale 1ns/1ps
module txq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             dropped
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic             full, do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dropped = push && full;
   assign dout    = mem[rd_ptr];

   // Pointer wrap: free roll-over for power-of-two depth, compare otherwise
   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

endmodule

// File: rtl/txq_shifter.sv
`timescale 1ns/1ps
module txq_shifter
   import txq_pkg::*;
#(
   parameter int W          = 8,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       cts_n,
   input  logic       have_data,
   input  logic [W-1:0] din,
   input  frame_cfg_t cfg,
   output logic       take,
   output logic       busy,
   output logic       txd
);
   localparam int FRAME_W = W + 1;        // data plus parity; stops shift in as ones
   localparam int REM_W   = $clog2(W + 4);

   frame_cfg_t         cfg_eff;
   logic [FRAME_W-1:0] sr;
   logic [REM_W-1:0]   rem;

   generate
      if (HAS_PARITY) begin : g_par
         assign cfg_eff = cfg;
      end else begin : g_nopar
         assign cfg_eff = '{short_word: cfg.short_word, par_en: 1'b0,
                            par_odd: 1'b0, two_stop: cfg.two_stop};
      end
   endgenerate

   function automatic logic [FRAME_W-1:0] pack_frame(input logic [W-1:0] d,
                                                     input frame_cfg_t c);
      logic [FRAME_W-1:0] f;
      logic [W-1:0]       sent;
      logic               pbit;
      sent = c.short_word ? {1'b0, d[W-2:0]} : d;
      pbit = c.par_en ? (c.par_odd ^ (^sent)) : 1'b1;
      f    = '1;
      if (c.short_word) begin
         f[W-1:0] = {pbit, d[W-2:0]};
      end else begin
         f[W-1:0] = d;
         f[W]     = pbit;
      end
      return f;
   endfunction

   function automatic logic [REM_W-1:0] frame_len(input frame_cfg_t c);
      return REM_W'(W) - REM_W'(c.short_word) + REM_W'(c.par_en)
             + REM_W'(1) + REM_W'(c.two_stop);
   endfunction

   assign take = !busy && have_data && !cts_n && baud_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         txd  <= 1'b1;
         sr   <= '1;
         rem  <= '0;
      end else if (baud_tick) begin
         if (busy) begin
            if (rem != '0) begin
               txd <= sr[0];
               sr  <= {1'b1, sr[FRAME_W-1:1]};
               rem <= rem - 1'b1;
            end else begin
               busy <= 1'b0;
               txd  <= 1'b1;
            end
         end else if (take) begin
            busy <= 1'b1;
            txd  <= 1'b0;
            sr   <= pack_frame(din, cfg_eff);
            rem  <= frame_len(cfg_eff);
         end
      end
   end

endmodule

// File: rtl/txq_events.sv
`timescale 1ns/1ps
module txq_events
   import txq_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  trig_sel_e        trig,
   input  logic             irq_en,
   input  logic             dreq_en,
   input  logic             dropped,
   input  logic             ovf_clr,
   output logic             empty_irq,
   output logic             xfer_req,
   output logic             ovf_flag
);
   logic [CNT_W-1:0] level;
   logic             low_water;

   always_comb begin
      unique case (trig)
         TRIG_1:  level = CNT_W'(1);
         TRIG_2:  level = CNT_W'(2);
         TRIG_4:  level = CNT_W'(4);
         default: level = CNT_W'(8);
      endcase
   end

   assign low_water = (count <= level);
   assign empty_irq = irq_en && low_water;
   assign xfer_req  = dreq_en && low_water;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_flag <= 1'b0;
      else if (dropped) ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
   end

endmodule

// File: rtl/txq_serializer.sv
`timescale 1ns/1ps
module txq_serializer
   import txq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 16,
   parameter bit HAS_PARITY = 1'b1,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cfg_short_word,
   input  logic              cfg_parity_en,
   input  logic              cfg_parity_odd,
   input  logic              cfg_two_stop,
   input  logic [1:0]        cfg_trig,
   input  logic              cfg_irq_en,
   input  logic              cfg_dreq_en,
   input  logic              ovf_clr,
   input  logic              baud_tick,
   input  logic              cts_n,
   output logic              txd,
   output logic [CNT_W-1:0]  fill_cnt,
   output logic              empty_irq,
   output logic              xfer_req,
   output logic              ovf_flag
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("txq_serializer: DATA_W must be at least 2");
      end
      if (DEPTH < 8) begin : g_bad_depth
         $error("txq_serializer: DEPTH must cover the largest threshold of 8");
      end
   endgenerate

   logic              take, busy, q_empty, dropped;
   logic [DATA_W-1:0] head;
   frame_cfg_t        fmt;

   assign fmt = '{short_word: cfg_short_word, par_en: cfg_parity_en,
                  par_odd: cfg_parity_odd, two_stop: cfg_two_stop};

   txq_fifo #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (wr_en),
      .pop     (take),
      .din     (wr_data),
      .dout    (head),
      .count   (fill_cnt),
      .empty   (q_empty),
      .dropped (dropped)
   );

   txq_shifter #(.W(DATA_W), .HAS_PARITY(HAS_PARITY)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .cts_n     (cts_n),
      .have_data (!q_empty),
      .din       (head),
      .cfg       (fmt),
      .take      (take),
      .busy      (busy),
      .txd       (txd)
   );

   txq_events #(.CNT_W(CNT_W)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .count     (fill_cnt),
      .trig      (trig_sel_e'(cfg_trig)),
      .irq_en    (cfg_irq_en),
      .dreq_en   (cfg_dreq_en),
      .dropped   (dropped),
      .ovf_clr   (ovf_clr),
      .empty_irq (empty_irq),
      .xfer_req  (xfer_req),
      .ovf_flag  (ovf_flag)
   );

endmodule

// File: rtl/txq_checker.sv
`timescale 1ns/1ps
module txq_checker #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             ovf_clr,
   input logic             baud_tick,
   input logic             cts_n,
   input logic             txd,
   input logic [CNT_W-1:0] fill_cnt,
   input logic             ovf_flag,
   input logic             take,
   input logic             busy
);
   assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CNT_W'(DEPTH));

   assert_fill_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_cnt == $past(fill_cnt)) ||
      (int'(fill_cnt) == int'($past(fill_cnt)) + 1) ||
      (int'(fill_cnt) == int'($past(fill_cnt)) - 1));

   assert_take_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (fill_cnt != '0));

   assert_drop_sets_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fill_cnt == CNT_W'(DEPTH)) |=> ovf_flag);

   assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

   assert_tick_paced_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(txd));

   assert_cts_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (!cts_n && baud_tick));

   assert_idle_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

endmodule

bind txq_serializer txq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .ovf_clr   (ovf_clr),
   .baud_tick (baud_tick),
   .cts_n     (cts_n),
   .txd       (txd),
   .fill_cnt  (fill_cnt),
   .ovf_flag  (ovf_flag),
   .take      (take),
   .busy      (busy)
);

// File: tb/sim_txq_serializer.sv
`timescale 1ns/1ps
module sim_txq_serializer;
   localparam int W     = 8;
   localparam int DEPTH = 16;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic cfg_short_word = 1'b0, cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0;
   logic cfg_two_stop = 1'b0, cfg_irq_en = 1'b1, cfg_dreq_en = 1'b1;
   logic [1:0] cfg_trig = 2'd0;
   logic ovf_clr = 1'b0, baud_tick = 1'b0, cts_n = 1'b0;
   logic txd, empty_irq, xfer_req, ovf_flag;
   logic [CNT_W-1:0] fill_cnt;

   always #2.5 clk = ~clk;

   txq_serializer #(.DATA_W(W), .DEPTH(DEPTH), .HAS_PARITY(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cfg_short_word(cfg_short_word), .cfg_parity_en(cfg_parity_en),
      .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop),
      .cfg_trig(cfg_trig), .cfg_irq_en(cfg_irq_en), .cfg_dreq_en(cfg_dreq_en),
      .ovf_clr(ovf_clr), .baud_tick(baud_tick), .cts_n(cts_n),
      .txd(txd), .fill_cnt(fill_cnt), .empty_irq(empty_irq),
      .xfer_req(xfer_req), .ovf_flag(ovf_flag));

   int    n_chk = 0, n_bad = 0;
   string cur_req = "R4";
   bit    done = 1'b0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Baud tick source
   int tick_div = 4;
   int tick_ctr = 0;
   always @(negedge clk) begin
      if (tick_ctr >= tick_div - 1) begin
         tick_ctr  = 0;
         baud_tick = 1'b1;
      end else begin
         tick_ctr++;
         baud_tick = 1'b0;
      end
   end

   // Behavioural reference model
   logic [W-1:0] mq[$];
   bit           m_bits[$];
   bit           m_busy = 1'b0, m_txd = 1'b1, m_ovf = 1'b0;

   always @(posedge clk) begin : model
      int           sz;
      logic [W-1:0] d;
      bit           p;
      int           nd;
      if (!rst_n) begin
         mq.delete();
         m_bits.delete();
         m_busy = 1'b0;
         m_txd  = 1'b1;
         m_ovf  = 1'b0;
      end else begin
         sz = mq.size();
         if (baud_tick) begin
            if (m_busy) begin
               if (m_bits.size() > 0) m_txd = m_bits.pop_front();
               else begin
                  m_busy = 1'b0;
                  m_txd  = 1'b1;
               end
            end else if (sz > 0 && !cts_n) begin
               d  = mq.pop_front();
               nd = cfg_short_word ? W - 1 : W;
               p  = cfg_parity_odd;
               for (int i = 0; i < nd; i++) begin
                  m_bits.push_back(d[i]);
                  p = p ^ d[i];
               end
               if (cfg_parity_en) m_bits.push_back(p);
               m_bits.push_back(1'b1);
               if (cfg_two_stop) m_bits.push_back(1'b1);
               m_txd  = 1'b0;
               m_busy = 1'b1;
            end
         end
         if (wr_en && sz < DEPTH) mq.push_back(wr_data);
         if (wr_en && sz >= DEPTH) m_ovf = 1'b1;
         else if (ovf_clr) m_ovf = 1'b0;
      end
   end

   // Per-cycle comparison, away from both edges
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         int lvl;
         bit low;
         lvl = 1 << cfg_trig;
         low = (mq.size() <= lvl);
         check(cur_req, "txd", int'(txd), int'(m_txd));
         check("R2", "fill_cnt", int'(fill_cnt), mq.size());
         check("R3", "ovf_flag", int'(ovf_flag), int'(m_ovf));
         check("R8", "empty_irq", int'(empty_irq), int'(cfg_irq_en && low));
         check("R9", "xfer_req", int'(xfer_req), int'(cfg_dreq_en && low));
      end
   end

   task automatic put(input logic [W-1:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic drain();
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         if (mq.size() == 0 && !m_busy) break;
      end
      repeat (tick_div * 2 + 2) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "txd in reset", int'(txd), 1);
      check("R1", "fill_cnt in reset", int'(fill_cnt), 0);
      check("R1", "ovf_flag in reset", int'(ovf_flag), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4: 8 data bits, one stop bit
      cur_req = "R4";
      put(8'hA5); put(8'h3C); put(8'hFF);
      drain();

      // R5: even then odd parity
      cur_req = "R5";
      cfg_parity_en = 1'b1; cfg_parity_odd = 1'b0;
      put(8'h5A); put(8'h81);
      drain();
      cfg_parity_odd = 1'b1;
      put(8'h7E); put(8'h01);
      drain();

      // R4: 7 data bits, even parity, two stop bits
      cur_req = "R4";
      cfg_short_word = 1'b1; cfg_parity_odd = 1'b0; cfg_two_stop = 1'b1;
      put(8'hFF); put(8'h80); put(8'h2B);
      drain();

      // R10: change the format during a frame
      cur_req = "R10";
      cfg_short_word = 1'b0; cfg_parity_en = 1'b0; cfg_two_stop = 1'b0;
      put(8'hC3);
      while (!m_busy) @(negedge clk);
      repeat (6) @(negedge clk);
      cfg_short_word = 1'b1; cfg_parity_en = 1'b1; cfg_two_stop = 1'b1;
      drain();
      cfg_short_word = 1'b0; cfg_parity_en = 1'b0; cfg_two_stop = 1'b0;

      // R6: clear-to-send holds off starts, but an open frame completes
      cur_req = "R6";
      cts_n = 1'b1;
      put(8'h11); put(8'h22); put(8'h33); put(8'h44);
      repeat (100) @(negedge clk);
      check("R6", "held fill_cnt", int'(fill_cnt), 4);
      check("R6", "held txd", int'(txd), 1);
      cts_n = 1'b0;
      while (!m_busy) @(negedge clk);
      cts_n = 1'b1;
      repeat (80) @(negedge clk);
      check("R6", "fill after one frame", int'(fill_cnt), 3);
      check("R6", "txd after frame", int'(txd), 1);
      cts_n = 1'b0;
      drain();

      // R3: overflow, set beats clear, then clear
      cur_req = "R4";
      cts_n = 1'b1;
      for (int i = 0; i < DEPTH + 2; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_data = W'(i * 37 + 5);
      end
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      check("R3", "fill at full", int'(fill_cnt), DEPTH);
      check("R3", "flag after drop", int'(ovf_flag), 1);
      wr_en = 1'b1; ovf_clr = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; ovf_clr = 1'b0;
      @(negedge clk);
      check("R3", "set wins over clear", int'(ovf_flag), 1);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      @(negedge clk);
      check("R3", "flag cleared", int'(ovf_flag), 0);

      // R8/R9: thresholds while draining a full queue
      tick_div = 2;
      cfg_trig = 2'd3;
      cts_n = 1'b0;
      drain();
      for (int t = 0; t < 3; t++) begin
         cfg_trig    = 2'(t);
         cfg_irq_en  = (t != 1);
         cfg_dreq_en = (t != 2);
         cts_n = 1'b1;
         for (int i = 0; i < DEPTH; i++) put(W'(i + t));
         cts_n = 1'b0;
         drain();
      end
      cfg_irq_en = 1'b1; cfg_dreq_en = 1'b1;

      // R7: idle gap between frames, tick on every clock
      cur_req = "R7";
      tick_div = 1;
      put(8'h00); put(8'h00); put(8'h80);
      drain();
      check("R7", "idle txd", int'(txd), 1);

      finish_run();
   end

endmodule